// File: doc/BRIEF.md
# ALU Status and Control Flag Register

This block holds the sixteen-bit condition word that sits beside an eight/sixteen-bit arithmetic unit. When an arithmetic or logic operation completes, the datapath presents the two operands, the result and the carry or borrow that left the top bit of the selected width. The block then derives six status flags and registers them. Three control flags (single-step trap, maskable-interrupt enable, and string direction) live in the same word. Only their own write strobe or a full-word load can change them.

The nine active flags sit at fixed positions of the output word, and the remaining seven positions always read zero. A full-word load, which a flag restore would use, overwrites every active flag in one cycle and has priority over the other two write paths. All pins are plain control and status signals. Each update is a one-cycle strobe with no handshake, and the new value appears on the output one clock after the strobe.

Top module: `alu_flag_reg`

## Requirements
- R1: Flag positions in `flags_o` are: carry at bit 0, parity at bit 2, half-carry at bit 4, zero at bit 6, sign at bit 7, trap at bit 8, interrupt enable at bit 9, direction at bit 10 and overflow at bit 11. Bits 1, 3, 5 and 12–15 read 0 at all times, including after a load of all ones.
- R2: For add (`op_cls`=00) and subtract (`op_cls`=01), carry takes `cy_out`. For a logic operation (`op_cls`=10 or 11), carry is cleared.
- R3: Parity is 1 when bits 7:0 of `res` hold an even number of ones, and 0 when that count is odd. This holds for both widths.
- R4: For add and subtract, half-carry is the carry or borrow from bit 3 into bit 4, taken as bit 4 of `opa ^ opb ^ res`. A logic operation leaves half-carry unchanged.
- R5: Zero is 1 exactly when the result is zero over the selected width: bits 7:0 when `wide`=0, all 16 bits when `wide`=1. Upper bits are ignored in byte mode.
- R6: Sign equals bit 7 of `res` when `wide`=0 and bit 15 when `wide`=1.
- R7: Overflow is set when the signed add or subtract result falls outside the range of the selected width. For a logic operation, overflow is cleared.
- R8: Trap, interrupt enable and direction change only on `ctl_we`, taking `ctl_val` bits 0, 1 and 2 respectively, or on a load. A status update leaves them unchanged.
- R9: `load_en` writes `load_word` with the unused positions forced to 0. It takes priority over `upd_en` and `ctl_we` in the same cycle.
- R10: After reset, `flags_o` is 0.
- R11: With `upd_en`, `ctl_we` and `load_en` all low, `flags_o` holds its value whatever the other inputs do.
- R12: Every write lands on `flags_o` one clock after its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_en | input | 1 | Update the status flags from this cycle's operation |
| op_cls | input | 2 | 00 add, 01 subtract, 1x logic |
| wide | input | 1 | 1 selects word width, 0 selects byte width |
| opa | input | DATA_W | First operand |
| opb | input | DATA_W | Second operand (subtrahend for subtract) |
| res | input | DATA_W | Operation result |
| cy_out | input | 1 | Carry or borrow out of the top bit of the selected width |
| ctl_we | input | 1 | Write the control flags |
| ctl_val | input | 3 | New control flags: bit0 trap, bit1 interrupt enable, bit2 direction |
| load_en | input | 1 | Load the whole flag word |
| load_word | input | 16 | Word to load |
| flags_o | output | 16 | Packed flag word |

## Verification
The bench builds the block at its defaults of DATA_W=16 and BYTE_W=8. At these values a byte-width sweep covers every first operand against a dense stride of second operands, for add, subtract and logic operations. Every nibble-carry, sign-crossing and zero-result boundary of the byte range is therefore reached. Word width is covered by a random sample that also hits 7FFFh/8000h edges. Byte-mode runs drive junk into the upper operand and result bytes, so the byte view is shown to ignore them.

// File: rtl/flagreg_pkg.sv
package flagreg_pkg;
  localparam int FLAG_W = 16;
  localparam int CF_B = 0;
  localparam int PF_B = 2;
  localparam int AF_B = 4;
  localparam int ZF_B = 6;
  localparam int SF_B = 7;
  localparam int TF_B = 8;
  localparam int IF_B = 9;
  localparam int DF_B = 10;
  localparam int OF_B = 11;

  localparam logic [FLAG_W-1:0] STAT_MASK =
    (FLAG_W'(1) << CF_B) | (FLAG_W'(1) << PF_B) | (FLAG_W'(1) << AF_B) |
    (FLAG_W'(1) << ZF_B) | (FLAG_W'(1) << SF_B) | (FLAG_W'(1) << OF_B);
  localparam logic [FLAG_W-1:0] CTL_MASK =
    (FLAG_W'(1) << TF_B) | (FLAG_W'(1) << IF_B) | (FLAG_W'(1) << DF_B);
  localparam logic [FLAG_W-1:0] ACTIVE_MASK = STAT_MASK | CTL_MASK;

  typedef enum logic [1:0] {
    OPC_ADD   = 2'b00,
    OPC_SUB   = 2'b01,
    OPC_LOGIC = 2'b10,
    OPC_LOG2  = 2'b11
  } opc_e;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } stat_t;

  function automatic logic [FLAG_W-1:0] pack_stat(stat_t s);
    logic [FLAG_W-1:0] w;
    w = '0;
    w[CF_B] = s.cf;
    w[PF_B] = s.pf;
    w[AF_B] = s.af;
    w[ZF_B] = s.zf;
    w[SF_B] = s.sf;
    w[OF_B] = s.of;
    return w;
  endfunction

  function automatic logic [FLAG_W-1:0] pack_ctl(logic [2:0] c);
    logic [FLAG_W-1:0] w;
    w = '0;
    w[TF_B] = c[0];
    w[IF_B] = c[1];
    w[DF_B] = c[2];
    return w;
  endfunction
endpackage

// File: rtl/flag_parity.sv
module flag_parity #(
  parameter int W = 8
) (
  input  logic [W-1:0] d,
  output logic         even
);
  logic [W:0] acc;
  assign acc[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_chain
    assign acc[i+1] = acc[i] ^ d[i];
  end
  assign even = ~acc[W];
endmodule

// File: rtl/flag_status_calc.sv
module flag_status_calc
  import flagreg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [1:0]        opc,
  input  logic              wide,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] res,
  input  logic              cy_out,
  input  logic              af_prev,
  output stat_t             st
);
  localparam int NIB_B = 4;
  localparam logic [DATA_W-1:0] BYTE_MASK = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
  localparam logic [DATA_W-1:0] NIB_SEL   = DATA_W'(1) << NIB_B;
  localparam logic [DATA_W-1:0] MSB_WORD  = DATA_W'(1) << (DATA_W-1);
  localparam logic [DATA_W-1:0] MSB_BYTE  = DATA_W'(1) << (BYTE_W-1);

  logic [DATA_W-1:0] wmask, msel;
  logic a_m, b_m, r_m, half, par_even, ovf_add, ovf_sub;
  opc_e op;

  assign op    = opc_e'(opc);
  assign wmask = wide ? '1 : BYTE_MASK;
  assign msel  = wide ? MSB_WORD : MSB_BYTE;
  assign a_m   = |(opa & msel);
  assign b_m   = |(opb & msel);
  assign r_m   = |(res & msel);
  assign half  = |((opa ^ opb ^ res) & NIB_SEL);

  assign ovf_add = (a_m == b_m) && (r_m != a_m);
  assign ovf_sub = (a_m != b_m) && (r_m != a_m);

  flag_parity #(.W(BYTE_W)) u_par (
    .d    (res[BYTE_W-1:0]),
    .even (par_even)
  );

  always_comb begin
    st.pf = par_even;
    st.zf = ((res & wmask) == '0);
    st.sf = r_m;
    unique case (op)
      OPC_ADD: begin
        st.cf = cy_out;
        st.af = half;
        st.of = ovf_add;
      end
      OPC_SUB: begin
        st.cf = cy_out;
        st.af = half;
        st.of = ovf_sub;
      end
      default: begin
        st.cf = 1'b0;
        st.af = af_prev;
        st.of = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import flagreg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [1:0]        op_cls,
  input  logic              wide,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] res,
  input  logic              cy_out,
  input  logic              ctl_we,
  input  logic [2:0]        ctl_val,
  input  logic              load_en,
  input  logic [15:0]       load_word,
  output logic [15:0]       flags_o
);
  logic [FLAG_W-1:0] flag_q, flag_d;
  stat_t st_next;

  flag_status_calc #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_calc (
    .opc     (op_cls),
    .wide    (wide),
    .opa     (opa),
    .opb     (opb),
    .res     (res),
    .cy_out  (cy_out),
    .af_prev (flag_q[AF_B]),
    .st      (st_next)
  );

  always_comb begin
    flag_d = flag_q;
    if (upd_en) flag_d = (flag_d & ~STAT_MASK) | pack_stat(st_next);
    if (ctl_we) flag_d = (flag_d & ~CTL_MASK) | pack_ctl(ctl_val);
    if (load_en) flag_d = load_word & ACTIVE_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flags_o = flag_q;

  // R8: control bits untouched without their own strobe or a load
  a_r8_ctl_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !ctl_we) |=> $stable(flags_o[DF_B:TF_B]));

  // R2 and R7: logic ops clear carry and overflow
  a_r2_logic_cf_of_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && upd_en && op_cls[1]) |=> (!flags_o[CF_B] && !flags_o[OF_B]));

  a_r4_logic_af_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && upd_en && op_cls[1]) |=> $stable(flags_o[AF_B]));

  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (flags_o == ($past(load_word) & ACTIVE_MASK)));

  a_r11_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !upd_en) |=> ((flags_o & STAT_MASK) == ($past(flags_o) & STAT_MASK)));

  a_r6_sign_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && upd_en) |=>
      (flags_o[SF_B] == $past(wide ? res[DATA_W-1] : res[BYTE_W-1])));

  a_r1_unused_low: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> ((flags_o & ~ACTIVE_MASK) == '0));
endmodule

// File: tb/sim_alu_flag_reg.sv
module sim_alu_flag_reg;
  logic clk = 1'b0;
  logic rst_n, upd_en, wide, cy_out, ctl_we, load_en;
  logic [1:0] op_cls;
  logic [15:0] opa, opb, res, load_word;
  logic [2:0] ctl_val;
  logic [15:0] flags_o;
  int checks = 0;
  int fails = 0;
  logic [15:0] expw = 16'h0;

  always #5 clk = ~clk;

  alu_flag_reg u0 (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_cls(op_cls), .wide(wide),
    .opa(opa), .opb(opb), .res(res), .cy_out(cy_out), .ctl_we(ctl_we),
    .ctl_val(ctl_val), .load_en(load_en), .load_word(load_word), .flags_o(flags_o)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // compare every field of flags_o with expw
  task automatic chk_all();
    chk("R2 carry",      16'(flags_o[0]),  16'(expw[0]));
    chk("R3 parity",     16'(flags_o[2]),  16'(expw[2]));
    chk("R4 halfcarry",  16'(flags_o[4]),  16'(expw[4]));
    chk("R5 zero",       16'(flags_o[6]),  16'(expw[6]));
    chk("R6 sign",       16'(flags_o[7]),  16'(expw[7]));
    chk("R7 overflow",   16'(flags_o[11]), 16'(expw[11]));
    chk("R8 control",    16'(flags_o[10:8]), 16'(expw[10:8]));
    chk("R1 unused",     flags_o & 16'hF02A, 16'h0);
  endtask

  function automatic int sgn(input logic [15:0] v, input logic w);
    if (w) return (v >= 16'h8000) ? int'(v) - 65536 : int'(v);
    return (v[7:0] >= 8'h80) ? int'(v[7:0]) - 256 : int'(v[7:0]);
  endfunction

  // drive one op at a negedge, check at the next negedge (R12: one clock)
  task automatic run_op(input logic [1:0] op, input logic w, input logic [15:0] a,
                        input logic [15:0] b, input logic [15:0] junk);
    logic [15:0] r, m, ea, eb;
    logic c, af, of;
    int sa, sb, sr, lim;
    m  = w ? 16'hFFFF : 16'h00FF;
    ea = a & m; eb = b & m;
    lim = w ? 32767 : 127;
    sa = sgn(a, w); sb = sgn(b, w);
    af = expw[4]; of = 1'b0; c = 1'b0;
    if (op == 2'b00) begin
      r = 16'(ea + eb);
      c = (32'(ea) + 32'(eb)) > 32'(m);
      af = ((a & 16'hF) + (b & 16'hF)) > 16'hF;
      sr = sa + sb;
      of = (sr > lim) || (sr < -lim - 1);
    end else if (op == 2'b01) begin
      r = 16'(ea - eb);
      c = ea < eb;
      af = (a & 16'hF) < (b & 16'hF);
      sr = sa - sb;
      of = (sr > lim) || (sr < -lim - 1);
    end else begin
      r = (op == 2'b10) ? (a & b) : (a ^ b);
    end
    r = w ? r : ((r & 16'h00FF) | (junk & 16'hFF00));
    expw[0]  = c;
    expw[2]  = ~^r[7:0];
    expw[4]  = af;
    expw[6]  = ((r & m) == 16'h0);
    expw[7]  = w ? r[15] : r[7];
    expw[11] = of;
    opa = w ? a : ((a & 16'h00FF) | (junk & 16'hFF00));
    opb = w ? b : ((b & 16'h00FF) | ({junk[7:0], junk[15:8]} & 16'hFF00));
    res = r; cy_out = c; op_cls = op; wide = w; upd_en = 1'b1;
    @(negedge clk);
    upd_en = 1'b0;
    chk_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; upd_en = 0; wide = 0; cy_out = 0; ctl_we = 0; load_en = 0;
    op_cls = 0; opa = 0; opb = 0; res = 0; load_word = 0; ctl_val = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset", flags_o, 16'h0000);

    // R8: write control flags
    ctl_val = 3'b101; ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
    expw[8] = 1'b1; expw[9] = 1'b0; expw[10] = 1'b1;
    chk("R8 ctl write", flags_o, 16'h0500);

    // R7 R2 R4: byte 7F + 01
    run_op(2'b00, 1'b0, 16'h007F, 16'h0001, 16'h0000);
    chk("R7 byte 7F+01 word", flags_o, 16'h0D90);

    // byte sweeps (junk in upper byte exercises R5 byte view)
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 5)
        run_op(2'b00, 1'b0, 16'(a), 16'(b), 16'(a * 97 + b * 13 + 16'h5A00));
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 5)
        run_op(2'b01, 1'b0, 16'(a), 16'(b), 16'(a * 31 + b * 7 + 16'hA500));
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 37)
        run_op({1'b1, 1'(a)}, 1'b0, 16'(a), 16'(b), 16'(a * 11 + 16'h3C00));

    // word edges and random words
    run_op(2'b00, 1'b1, 16'h7FFF, 16'h0001, 16'h0);
    chk("R7 word 7FFF+1", flags_o & 16'h0880, 16'h0880);
    run_op(2'b01, 1'b1, 16'h8000, 16'h0001, 16'h0);
    run_op(2'b00, 1'b1, 16'hFFFF, 16'h0001, 16'h0);
    chk("R5 word wrap zero", 16'(flags_o[6]), 16'h1);
    for (int i = 0; i < 3000; i++) begin
      run_op(2'b00, 1'b1, 16'($urandom), 16'($urandom), 16'h0);
      run_op(2'b01, 1'b1, 16'($urandom), 16'($urandom), 16'h0);
      run_op({1'b1, 1'(i)}, 1'b1, 16'($urandom), 16'($urandom), 16'h0);
    end

    // R11: no strobe, inputs wander, output holds
    for (int i = 0; i < 20; i++) begin
      opa = 16'($urandom); opb = 16'($urandom); res = 16'($urandom);
      cy_out = 1'($urandom); op_cls = 2'($urandom); ctl_val = 3'($urandom);
      @(negedge clk);
      chk("R11 hold", flags_o, expw);
    end

    // R9 and R1: load all ones, with competing strobes
    load_word = 16'hFFFF; load_en = 1'b1; upd_en = 1'b1; ctl_we = 1'b1;
    ctl_val = 3'b000; op_cls = 2'b10; res = 16'h0000;
    @(negedge clk);
    load_en = 0; upd_en = 0; ctl_we = 0;
    chk("R1 R9 load ones", flags_o, 16'h0FD5);
    expw = 16'h0FD5;

    load_word = 16'h0000; load_en = 1'b1;
    @(negedge clk);
    load_en = 1'b0;
    chk("R9 load zero", flags_o, 16'h0000);
    expw = 16'h0000;

    // R8: status update must leave control bits alone
    load_word = 16'h0700; load_en = 1'b1;
    @(negedge clk);
    load_en = 1'b0;
    expw = 16'h0700;
    run_op(2'b01, 1'b1, 16'h0000, 16'h0001, 16'h0);
    chk("R8 ctl after sub", flags_o & 16'h0700, 16'h0700);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule